// File: doc/BRIEF.md
# Flash Write-Cycle Protection Gate

This block sits between the control pins of a flash device and its command state machine. It decides which bus write cycles the command logic may see. The chip-enable, write-enable and output-enable strobes (all active low) are sampled on a system clock and filtered for noise. A write cycle exists only while chip enable and write enable are low and output enable is high. When the first of write enable or chip enable rises, the block sends one qualified write pulse with the address and data captured at that moment.

Several conditions stop the pulse. A low-supply lockout flag, a missing power-good indication or a low level on the external reset pin each stop it. Each of these also holds the command register in its cleared, read-array state. A write that is already asserted when power comes up, or that is still open when a lockout ends, is thrown away whole. Only write cycles that open after the strobes have been seen released are accepted.

A separate high-voltage detect flag on the reset pin raises an override that lifts sector protection. The override drops again as soon as the flag clears.

Top module: `flash_write_gate`

## Requirements
- R1: A write cycle exists only while filtered chip enable = 0, write enable = 0 and output enable = 1. `wr_stb` is a single-cycle pulse, issued once when filtered write enable or chip enable rises to end such a cycle. A cycle ended by output enable going low gives no pulse, and a later rise of the other strobe gives no second pulse.
- R2: In the cycle where `wr_stb` is high, `wr_addr` and `wr_data` hold the `addr_in` and `data_in` values present when the pulse was decided. The registers keep those values until the next pulse.
- R3: While `vlow_lock` = 1, no write pulse is issued. A write cycle that is still open when `vlow_lock` returns to 0 is also dropped.
- R4: `cmd_clear` is 1 in the clock cycle after any cycle in which `vlow_lock` = 1, `pwr_good` = 0 or `rst_pin_n` = 0. Otherwise it is 0.
- R5: Each strobe is sampled into a register and then filtered. A new level is accepted only after `FILT_LEN` consecutive samples at that level. A pulse shorter than `FILT_LEN` clocks has no effect. When write enable rises at the end of a valid cycle, `wr_stb` goes high at the (`FILT_LEN`+2)-th rising clock edge after the change.
- R6: A write cycle that is already asserted when `pwr_good` rises ends without a pulse. The next complete write cycle is accepted.
- R7: `unprot_ovr` is 1 in the clock cycle after a cycle with `hv_reset` = 1, `rst_pin_n` = 1 and `pwr_good` = 1. It is 0 one cycle after `hv_reset` clears.
- R8: During `rst_n` = 0, the outputs are `wr_stb` = 0, `wr_addr` = 0, `wr_data` = 0, `unprot_ovr` = 0 and `cmd_clear` = 1.
- R9: While `rst_pin_n` = 0, no write pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and system clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| ce_n | input | 1 | Chip-enable pin, active low, unfiltered |
| we_n | input | 1 | Write-enable pin, active low, unfiltered |
| oe_n | input | 1 | Output-enable pin, active low, unfiltered |
| rst_pin_n | input | 1 | External reset pin at a normal logic level, active low |
| hv_reset | input | 1 | High-voltage level detected on the reset pin |
| vlow_lock | input | 1 | Supply below the lockout threshold |
| pwr_good | input | 1 | Supply has reached its operating range |
| addr_in | input | ADDR_W | Bus address |
| data_in | input | DATA_W | Bus data |
| wr_stb | output | 1 | Qualified write pulse to the command logic |
| wr_addr | output | ADDR_W | Address captured with the pulse |
| wr_data | output | DATA_W | Data captured with the pulse |
| cmd_clear | output | 1 | Hold the command register in its read-array reset |
| unprot_ovr | output | 1 | Lift sector protection while high |

## Verification
The bench builds the block with `FILT_LEN` = 3 and 8-bit address and data. With a filter length of three, pulses of one and two clocks both fall below the threshold. A pulse of exactly three clocks sits on the threshold and must pass, which exercises both sides of the filter boundary. The three-sample delay also gives a fixed and visible latency from a pin rising to the write pulse, so that latency is checked to the exact edge.

// File: rtl/wpg_pkg.sv
// Shared definitions for the flash write protection gate.
// Assumes the three control strobes are carried as one vector in the pin order below.
package wpg_pkg;
    typedef enum int {
        PIN_CE = 0,
        PIN_WE = 1,
        PIN_OE = 2
    } ctrl_pin_e;

    localparam int NUM_PINS = 3;

    // True when the filtered strobes describe an open write cycle.
    function automatic logic write_open(input logic [NUM_PINS-1:0] lv);
        return !lv[PIN_CE] && !lv[PIN_WE] && lv[PIN_OE];
    endfunction
endpackage

// File: rtl/wpg_pin_filter.sv
// Noise filter for one active-low control pin.
// The pin is sampled into a register. The filtered level follows the sample only
// after FILT_LEN consecutive samples that disagree with it.
// Assumes the pin is synchronous to clk or already synchronized, and that it idles high.
module wpg_pin_filter #(
    parameter int FILT_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_flt
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic          samp;
    logic [CW-1:0] run;

    // Sample the pin and accept a new level after a full run of agreeing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp    <= 1'b1;
            pin_flt <= 1'b1;
            run     <= '0;
        end else begin
            samp <= pin_raw;
            if (samp == pin_flt) begin
                run <= '0;
            end else if (run == LAST) begin
                pin_flt <= samp;
                run     <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end

    AST_FLT_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_flt != $past(pin_flt)) |-> (pin_flt == $past(samp))); // R5
endmodule

// File: rtl/wpg_guard.sv
// Supply and reset supervision for the write gate.
// Keeps a write inhibit that is set by any unsafe condition. The inhibit clears only
// after the filtered write or chip enable is seen released in a safe state, which
// discards a write that was already open at power-up or when a lockout ended.
// Also drives the command-register clear and the sector-unprotect override.
module wpg_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic vlow_lock,
    input  logic pwr_good,
    input  logic rst_pin_n,
    input  logic hv_reset,
    input  logic we_flt,
    input  logic ce_flt,
    output logic blk,
    output logic cmd_clear,
    output logic unprot_ovr
);
    logic unsafe;
    logic inh;

    assign unsafe = vlow_lock | ~pwr_good | ~rst_pin_n;
    assign blk    = inh | unsafe;

    // Hold the inhibit until a strobe is released while conditions are safe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            inh <= 1'b1;
        else if (unsafe)
            inh <= 1'b1;
        else if (we_flt | ce_flt)
            inh <= 1'b0;
    end

    // Register the command clear and the protection override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_clear  <= 1'b1;
            unprot_ovr <= 1'b0;
        end else begin
            cmd_clear  <= unsafe;
            unprot_ovr <= hv_reset & rst_pin_n & pwr_good;
        end
    end

    AST_CLEAR_IN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vlow_lock) |-> cmd_clear); // R4
    AST_OVR_NEEDS_HV: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hv_reset) |-> !unprot_ovr); // R7
endmodule

// File: rtl/wpg_strobe.sv
// Write qualification and capture.
// Tracks an open write cycle on the filtered strobes. When write or chip enable rises
// to end that cycle and the guard does not block it, the module issues a one-cycle
// pulse and captures the bus.
module wpg_strobe #(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [wpg_pkg::NUM_PINS-1:0]  flt,
    input  logic                          blk,
    input  logic [ADDR_W-1:0]             addr_in,
    input  logic [DATA_W-1:0]             data_in,
    output logic                          wr_stb,
    output logic [ADDR_W-1:0]             wr_addr,
    output logic [DATA_W-1:0]             wr_data
);
    import wpg_pkg::*;

    logic open_now;
    logic open_q;
    logic ends_by_strobe;
    logic fire;

    assign open_now       = write_open(flt);
    assign ends_by_strobe = open_q & (flt[PIN_WE] | flt[PIN_CE]);
    assign fire           = ends_by_strobe & ~blk;

    // Remember whether a write cycle was open in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_q <= 1'b0;
        else
            open_q <= open_now;
    end

    // Issue the pulse and capture address and data with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= fire;
            if (fire) begin
                wr_addr <= addr_in;
                wr_data <= data_in;
            end
        end
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R1
    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> $stable(wr_addr)); // R2
endmodule

// File: rtl/flash_write_gate.sv
// Flash write-cycle protection gate, top level.
// Filters the three control strobes, supervises supply and reset conditions and
// passes qualified write pulses to the command logic.
// Assumes the strobes idle high and pwr_good is low while rst_n is asserted at power-on.
module flash_write_gate #(
    parameter int FILT_LEN = 2,
    parameter int ADDR_W   = 21,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              rst_pin_n,
    input  logic              hv_reset,
    input  logic              vlow_lock,
    input  logic              pwr_good,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              cmd_clear,
    output logic              unprot_ovr
);
    import wpg_pkg::*;

    logic [NUM_PINS-1:0] raw;
    logic [NUM_PINS-1:0] flt;
    logic                blk;

    assign raw[PIN_CE] = ce_n;
    assign raw[PIN_WE] = we_n;
    assign raw[PIN_OE] = oe_n;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_filt
        wpg_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_raw (raw[g]),
            .pin_flt (flt[g])
        );
    end

    wpg_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .vlow_lock  (vlow_lock),
        .pwr_good   (pwr_good),
        .rst_pin_n  (rst_pin_n),
        .hv_reset   (hv_reset),
        .we_flt     (flt[PIN_WE]),
        .ce_flt     (flt[PIN_CE]),
        .blk        (blk),
        .cmd_clear  (cmd_clear),
        .unprot_ovr (unprot_ovr)
    );

    wpg_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .flt     (flt),
        .blk     (blk),
        .addr_in (addr_in),
        .data_in (data_in),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    AST_LOCK_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vlow_lock) |-> !wr_stb); // R3
    AST_PWRUP_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pwr_good) |-> !wr_stb); // R6
    AST_PIN_RST_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_pin_n) |-> !wr_stb); // R9
endmodule

// File: tb/flash_write_gate_test.sv
module flash_write_gate_test;
    localparam int FL = 3;
    localparam int AW = 8;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic rst_pin_n = 1'b1, hv_reset = 1'b0, vlow_lock = 1'b0, pwr_good = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic wr_stb, cmd_clear, unprot_ovr;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    logic [AW-1:0] seen_addr = '0;
    logic [DW-1:0] seen_data = '0;
    bit done = 0;

    always #2 clk = ~clk;

    flash_write_gate #(.FILT_LEN(FL), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .rst_pin_n(rst_pin_n), .hv_reset(hv_reset), .vlow_lock(vlow_lock),
        .pwr_good(pwr_good), .addr_in(addr_in), .data_in(data_in),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_clear(cmd_clear), .unprot_ovr(unprot_ovr)
    );

    // Count pulses and record what was captured with each one.
    always @(posedge clk) begin
        if (wr_stb) begin
            stb_cnt   <= stb_cnt + 1;
            seen_addr <= wr_addr;
            seen_data <= wr_data;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Open a write cycle (CE and WE low) for len clocks, then release both strobes.
    task automatic pulse(input int len, input logic oe, input logic lk);
        @(negedge clk);
        vlow_lock = lk;
        idle(2);
        oe_n = oe; ce_n = 1'b0; we_n = 1'b0;
        idle(len);
        ce_n = 1'b1; we_n = 1'b1;
        idle(FL + 8);
        oe_n = 1'b1; vlow_lock = 1'b0;
        idle(FL + 4);
    endtask

    typedef struct packed {
        logic       lk;
        logic       oe;
        logic [7:0] len;
        logic [1:0] exp;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{1'b0, 1'b1, 8'd10, 2'd1},   // R1 normal write
        '{1'b0, 1'b1, 8'd2,  2'd0},   // R5 glitch one short of the filter
        '{1'b0, 1'b1, 8'd3,  2'd1},   // R5 exactly at the filter length
        '{1'b0, 1'b0, 8'd10, 2'd0},   // R1 output enable low
        '{1'b1, 1'b1, 8'd10, 2'd0},   // R3 under lockout
        '{1'b0, 1'b1, 8'd1,  2'd0},   // R5 single-clock glitch
        '{1'b0, 1'b1, 8'd20, 2'd1}    // R1 long write
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        // R8 reset state; a write is already asserted at power-on.
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        idle(4);
        chk("R8 wr_stb", wr_stb, 0);
        chk("R8 wr_addr", wr_addr, 0);
        chk("R8 wr_data", wr_data, 0);
        chk("R8 unprot_ovr", unprot_ovr, 0);
        chk("R8 cmd_clear", cmd_clear, 1);
        rst_n = 1'b1;
        idle(10);
        chk("R4 clear while power not good", cmd_clear, 1);
        pwr_good = 1'b1;
        idle(2);
        chk("R4 clear drops with power good", cmd_clear, 0);
        idle(8);
        // R6 power-up write ends without a pulse.
        base = stb_cnt;
        we_n = 1'b1; ce_n = 1'b1;
        idle(FL + 8);
        chk("R6 power-up write blocked", stb_cnt - base, 0);
        base = stb_cnt;
        pulse(10, 1'b1, 1'b0);
        chk("R6 next write accepted", stb_cnt - base, 1);

        // Vector table.
        for (int i = 0; i < 7; i++) begin
            addr_in = AW'(8'hA0 + i);
            data_in = DW'(8'h50 + i);
            base = stb_cnt;
            pulse(int'(VEC[i].len), VEC[i].oe, VEC[i].lk);
            chk("R1/R3/R5 vector pulse count", stb_cnt - base, int'(VEC[i].exp));
            if (VEC[i].exp != 0) begin
                chk("R2 captured addr", seen_addr, 8'hA0 + i);
                chk("R2 captured data", seen_data, 8'h50 + i);
            end
        end

        // R5 exact latency on a write-enable rise; R1 a later CE rise adds no pulse.
        addr_in = 8'h3C; data_in = 8'hC3;
        ce_n = 1'b0; we_n = 1'b0;
        idle(10);
        base = stb_cnt;
        we_n = 1'b1;
        idle(FL + 1);
        chk("R5 no pulse before latency", wr_stb, 0);
        idle(1);
        chk("R5 pulse at latency", wr_stb, 1);
        chk("R2 addr on pulse", wr_addr, 8'h3C);
        chk("R2 data on pulse", wr_data, 8'hC3);
        idle(4);
        ce_n = 1'b1;
        idle(FL + 6);
        chk("R1 single pulse per cycle", stb_cnt - base, 1);

        // R1 cycle ended by output enable going low.
        base = stb_cnt;
        ce_n = 1'b0; we_n = 1'b0;
        idle(8);
        oe_n = 1'b0;
        idle(8);
        we_n = 1'b1; ce_n = 1'b1;
        idle(FL + 6);
        oe_n = 1'b1;
        idle(FL + 4);
        chk("R1 OE low ends without pulse", stb_cnt - base, 0);

        // R3 write spanning a lockout is dropped; R4 clear during lockout.
        base = stb_cnt;
        ce_n = 1'b0; we_n = 1'b0;
        idle(8);
        vlow_lock = 1'b1;
        idle(3);
        chk("R4 clear in lockout", cmd_clear, 1);
        vlow_lock = 1'b0;
        idle(6);
        we_n = 1'b1; ce_n = 1'b1;
        idle(FL + 6);
        chk("R3 write spanning lockout dropped", stb_cnt - base, 0);
        base = stb_cnt;
        pulse(10, 1'b1, 1'b0);
        chk("R3 writes resume after lockout", stb_cnt - base, 1);

        // R9 reset pin low blocks writes.
        rst_pin_n = 1'b0;
        base = stb_cnt;
        pulse(10, 1'b1, 1'b0);
        chk("R9 no write with reset pin low", stb_cnt - base, 0);
        chk("R4 clear with reset pin low", cmd_clear, 1);
        rst_pin_n = 1'b1;
        idle(4);

        // R7 protection override follows the high-voltage flag.
        chk("R7 override off", unprot_ovr, 0);
        hv_reset = 1'b1;
        idle(1);
        chk("R7 override on", unprot_ovr, 1);
        idle(5);
        hv_reset = 1'b0;
        idle(1);
        chk("R7 override released", unprot_ovr, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule